// File: doc/BRIEF.md
# Two-Level Paging Unit with Translation Cache

The unit turns 32-bit linear addresses into physical addresses for 4 KB pages. A 32-entry translation cache sits in front of a two-level table walk. A request that hits the cache returns its physical address one cycle after it is accepted, with no memory traffic. A request that misses starts a walk. The walk reads one directory entry and one table entry through a single memory read port, installs the translation and returns the address. When the paging enable input is low, the unit passes the linear address straight through.

The directory base input gives the physical address of the directory. Software pulses the flush input whenever it rewrites that base, and the pulse invalidates every cached translation. Only one walk can be in flight at a time, and the request side is held off until that walk ends. If either table entry has its present bit clear, the unit returns a fault instead of an address and caches nothing.

Top module: `page_xlate_unit`

## Requirements
- R1: With `pg_en` low, an accepted request returns `rsp_phys` equal to `req_lin`, with no fault and no memory read, one cycle after acceptance.
- R2: On every non-faulting response, bits 11:0 of `rsp_phys` equal bits 11:0 of the accepted linear address.
- R3: A walk reads the directory entry at `dir_base + lin[31:22]*4`, then the table entry at `{dir_entry[31:12], 12'h000} + lin[21:12]*4`. The result is `{table_entry[31:12], lin[11:0]}`.
- R4: A request whose page is cached responds one cycle after acceptance with the cached translation and issues no memory read.
- R5: Bit 0 of each entry is the present bit. If it is clear in the directory entry, the unit faults after one read. If it is clear in the table entry, the unit faults after two reads. A faulting walk installs nothing, so repeating the request walks again.
- R6: The cache holds 32 translations. An empty slot is filled first. When every slot is full, the least recently used translation is replaced, and a hit counts as a use.
- R7: A `tlb_flush` pulse invalidates every entry. A request accepted in the same cycle as the pulse is treated as a miss.
- R8: A flush during a walk still lets the walk respond with its result, but that result is not installed.
- R9: `req_ready` is low from the cycle after a missing request is accepted until the cycle in which its response is presented. At that point it is high again.
- R10: While a read is pending and no read data has arrived, `mem_req_valid` stays high and `mem_req_addr` stays stable.
- R11: `rsp_valid` is a single-cycle pulse for each accepted request, and `rsp_fault` is only high together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pg_en | input | 1 | Paging enable; low means the linear address is used as the physical address |
| dir_base | input | 32 | Physical address of the page directory |
| tlb_flush | input | 1 | Single-cycle pulse that invalidates all cached translations |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit can accept a request |
| req_lin | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_phys | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Page not present |
| mem_req_valid | output | 1 | Entry read pending |
| mem_req_addr | output | 32 | Address of the entry being read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read data |

## Verification
Several properties are checked on every cycle: the bypass path, the preserved page offset, the timing of a cache hit with no read issued, at most one cache match, the stable held read request, and the fact that no request is accepted while a read is pending. Other behaviour shows only in the bench's scenarios. These are the arithmetic of the walk addresses, the present-bit faults and the fact that faults are not cached, the order of least-recently-used eviction, and the effect of a flush in three positions. The three flush positions are between requests, together with a request, and during a walk. The bench observes each of these through the returned addresses and by counting memory reads.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int ADDR_W    = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int ENT_BYTES = 4;
    localparam int PRES_BIT  = 0;

    typedef enum logic [1:0] {
        W_IDLE,
        W_DIR,
        W_TBL
    } walk_st_e;
endpackage

// File: rtl/tlb_lru_array.sv
module tlb_lru_array #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               look_en,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic               hit,
    output logic [PPN_W-1:0]   hit_ppn,
    output logic [ENTRIES-1:0] hit_vec,
    input  logic               ins_en,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PPN_W-1:0]   ins_ppn
);
    localparam int AGE_W = $clog2(ENTRIES);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ENTRIES - 1);

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic [AGE_W-1:0] age;
    } ent_t;

    ent_t ent_d [ENTRIES];
    ent_t ent_q [ENTRIES];

    logic [ENTRIES-1:0] match;
    logic [AGE_W-1:0]   hit_idx;
    logic [AGE_W-1:0]   victim;
    logic               vic_found;
    logic               touch;
    logic [AGE_W-1:0]   touch_idx;
    logic               do_install;

    // one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_q[g].vld && (ent_q[g].vpn == look_vpn);
    end

    assign hit     = (|match) && !flush;
    assign hit_vec = match;

    always_comb begin
        hit_idx = '0;
        hit_ppn = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (match[k]) begin
                hit_idx = hit_idx | AGE_W'(k);
            end
            hit_ppn = hit_ppn | ({PPN_W{match[k]}} & ent_q[k].ppn);
        end
    end

    // empty slot first, otherwise the oldest one
    always_comb begin
        victim    = '0;
        vic_found = 1'b0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (!vic_found && !ent_q[k].vld) begin
                victim    = AGE_W'(k);
                vic_found = 1'b1;
            end
        end
        if (!vic_found) begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (ent_q[k].age == AGE_MAX) begin
                    victim = AGE_W'(k);
                end
            end
        end
    end

    assign do_install = ins_en && !flush;
    assign touch      = (look_en && hit) || do_install;
    assign touch_idx  = (look_en && hit) ? hit_idx : victim;

    always_comb begin
        for (int k = 0; k < ENTRIES; k++) begin
            ent_d[k] = ent_q[k];
        end
        if (do_install) begin
            ent_d[victim].vld = 1'b1;
            ent_d[victim].vpn = ins_vpn;
            ent_d[victim].ppn = ins_ppn;
        end
        if (touch) begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (AGE_W'(k) == touch_idx) begin
                    ent_d[k].age = '0;
                end else if (ent_q[k].age < ent_q[touch_idx].age) begin
                    ent_d[k].age = ent_q[k].age + 1'b1;
                end
            end
        end
        if (flush) begin
            for (int k = 0; k < ENTRIES; k++) begin
                ent_d[k].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ENTRIES; k++) begin
                ent_q[k].vld <= 1'b0;
                ent_q[k].vpn <= '0;
                ent_q[k].ppn <= '0;
                ent_q[k].age <= AGE_W'(k);
            end
        end else begin
            for (int k = 0; k < ENTRIES; k++) begin
                ent_q[k] <= ent_d[k];
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pxu_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int OW  = OFF_W,
    parameter int IW  = IDX_W,
    parameter int EB  = ENT_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_lin,
    input  logic [AW-1:0]    dir_base,
    input  logic             flush,
    output logic             mem_req_valid,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [AW-1:0]    mem_rsp_data,
    output logic             busy,
    output logic             done,
    output logic             done_fault,
    output logic [AW-1:0]    done_phys,
    output logic             ins_en,
    output logic [AW-OW-1:0] ins_vpn,
    output logic [AW-OW-1:0] ins_ppn
);
    localparam int SHIFT = $clog2(EB);

    typedef struct packed {
        walk_st_e     st;
        logic [AW-1:0] lin;
        logic [AW-1:0] tbase;
        logic          drop;
    } wk_t;

    wk_t wk_d, wk_q;

    logic [IW-1:0] dir_idx;
    logic [IW-1:0] tbl_idx;
    logic [AW-1:0] dir_addr;
    logic [AW-1:0] tbl_addr;
    logic          present;
    logic          walk_unused_bits;

    assign dir_idx  = wk_q.lin[AW-1 -: IW];
    assign tbl_idx  = wk_q.lin[OW +: IW];
    assign dir_addr = dir_base + (AW'(dir_idx) << SHIFT);
    assign tbl_addr = wk_q.tbase + (AW'(tbl_idx) << SHIFT);
    assign present  = mem_rsp_data[PRES_BIT];
    assign walk_unused_bits = ^mem_rsp_data[OW-1:1];

    assign busy    = (wk_q.st != W_IDLE);
    assign ins_vpn = wk_q.lin[AW-1:OW];
    assign ins_ppn = mem_rsp_data[AW-1:OW];

    always_comb begin
        wk_d          = wk_q;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        done          = 1'b0;
        done_fault    = 1'b0;
        done_phys     = '0;
        ins_en        = 1'b0;
        unique case (wk_q.st)
            W_IDLE: begin
                if (start) begin
                    wk_d.st   = W_DIR;
                    wk_d.lin  = start_lin;
                    wk_d.drop = 1'b0;
                end
            end
            W_DIR: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_addr;
                if (flush) begin
                    wk_d.drop = 1'b1;
                end
                if (mem_rsp_valid) begin
                    if (!present) begin
                        done       = 1'b1;
                        done_fault = 1'b1;
                        wk_d.st    = W_IDLE;
                    end else begin
                        wk_d.tbase = {mem_rsp_data[AW-1:OW], {OW{1'b0}}};
                        wk_d.st    = W_TBL;
                    end
                end
            end
            W_TBL: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tbl_addr;
                if (flush) begin
                    wk_d.drop = 1'b1;
                end
                if (mem_rsp_valid) begin
                    done    = 1'b1;
                    wk_d.st = W_IDLE;
                    if (!present) begin
                        done_fault = 1'b1;
                    end else begin
                        done_phys = {mem_rsp_data[AW-1:OW], wk_q.lin[OW-1:0]};
                        ins_en    = !wk_q.drop && !flush;
                    end
                end
            end
            default: wk_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q <= '{st: W_IDLE, lin: '0, tbase: '0, drop: 1'b0};
        end else begin
            wk_q <= wk_d;
        end
    end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import pxu_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              tlb_flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_lin,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic              rsp_fault,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int VPN_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              vld;
        logic              flt;
        logic [ADDR_W-1:0] pa;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic               accept;
    logic               look_en;
    logic               tlb_hit;
    logic [VPN_W-1:0]   tlb_ppn;
    logic [ENTRIES-1:0] tlb_hit_vec;
    logic               walk_start;
    logic               walk_busy;
    logic               walk_done;
    logic               walk_fault;
    logic [ADDR_W-1:0]  walk_phys;
    logic               ins_en;
    logic [VPN_W-1:0]   ins_vpn;
    logic [VPN_W-1:0]   ins_ppn;

    assign req_ready  = !walk_busy;
    assign accept     = req_valid && req_ready;
    assign look_en    = accept && pg_en;
    assign walk_start = look_en && !tlb_hit;

    tlb_lru_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (VPN_W)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tlb_flush),
        .look_en  (look_en),
        .look_vpn (req_lin[ADDR_W-1:OFF_W]),
        .hit      (tlb_hit),
        .hit_ppn  (tlb_ppn),
        .hit_vec  (tlb_hit_vec),
        .ins_en   (ins_en),
        .ins_vpn  (ins_vpn),
        .ins_ppn  (ins_ppn)
    );

    pt_walker #(
        .AW (ADDR_W),
        .OW (OFF_W),
        .IW (IDX_W),
        .EB (ENT_BYTES)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (walk_start),
        .start_lin     (req_lin),
        .dir_base      (dir_base),
        .flush         (tlb_flush),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (walk_busy),
        .done          (walk_done),
        .done_fault    (walk_fault),
        .done_phys     (walk_phys),
        .ins_en        (ins_en),
        .ins_vpn       (ins_vpn),
        .ins_ppn       (ins_ppn)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = 1'b0;
        rsp_d.flt = 1'b0;
        if (accept && !pg_en) begin
            rsp_d.vld = 1'b1;
            rsp_d.pa  = req_lin;
        end else if (look_en && tlb_hit) begin
            rsp_d.vld = 1'b1;
            rsp_d.pa  = {tlb_ppn, req_lin[OFF_W-1:0]};
        end else if (walk_done) begin
            rsp_d.vld = 1'b1;
            rsp_d.flt = walk_fault;
            rsp_d.pa  = walk_phys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_fault = rsp_q.flt;
    assign rsp_phys  = rsp_q.pa;
endmodule

// File: rtl/page_xlate_checks.sv
module page_xlate_checks #(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pg_en,
    input logic               req_valid,
    input logic               req_ready,
    input logic [31:0]        req_lin,
    input logic               rsp_valid,
    input logic [31:0]        rsp_phys,
    input logic               rsp_fault,
    input logic               mem_req_valid,
    input logic [31:0]        mem_req_addr,
    input logic               mem_rsp_valid,
    input logic               tlb_hit,
    input logic [ENTRIES-1:0] tlb_hit_vec
);
    logic        acc;
    logic [31:0] lin_cap;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_cap <= '0;
        end else if (acc) begin
            lin_cap <= req_lin;
        end
    end

    // R1: bypass returns the linear address next cycle
    a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !pg_en |=> rsp_valid && !rsp_fault && (rsp_phys == $past(req_lin)));

    // R1: bypass issues no memory read
    a_r1_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !pg_en |=> !mem_req_valid);

    // R2: page offset preserved
    a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_phys[11:0] == lin_cap[11:0]);

    // R4: hit answers next cycle without a read
    a_r4_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
        acc && pg_en && tlb_hit |=> rsp_valid && !mem_req_valid);

    // R6: a page sits in at most one slot
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tlb_hit_vec));

    // R9: nothing accepted while a read is pending
    a_r9_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R10: pending read held steady
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_addr));

    // R11: fault only with a response
    a_r11_fault_qual: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);
endmodule

bind page_xlate_unit page_xlate_checks #(.ENTRIES(ENTRIES)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .pg_en         (pg_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_lin       (req_lin),
    .rsp_valid     (rsp_valid),
    .rsp_phys      (rsp_phys),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .tlb_hit       (tlb_hit),
    .tlb_hit_vec   (tlb_hit_vec)
);

// File: tb/tb_page_xlate_unit.sv
`timescale 1ns/1ps
module tb_page_xlate_unit;
    localparam logic [31:0] DIR_A = 32'h0000_2000;
    localparam logic [31:0] DIR_B = 32'h0000_3000;
    localparam logic [31:0] TBL_A = 32'h0100_0000;
    localparam logic [31:0] TBL_B = 32'h0200_0000;
    localparam int          LAT   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_en = 1'b0;
    logic [31:0] dir_base = DIR_A;
    logic        tlb_flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        rsp_valid;
    logic [31:0] rsp_phys;
    logic        rsp_fault;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int total = 0;
    int bad = 0;
    int mem_reads = 0;

    always #2.5 clk = ~clk;

    page_xlate_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pg_en         (pg_en),
        .dir_base      (dir_base),
        .tlb_flush     (tlb_flush),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_lin       (req_lin),
        .rsp_valid     (rsp_valid),
        .rsp_phys      (rsp_phys),
        .rsp_fault     (rsp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    function automatic logic [19:0] ppn_of(input logic [31:0] rb, input logic [9:0] i,
                                           input logic [9:0] j);
        logic [31:0] v;
        v = ((rb >> 12) ^ (32'(i) * 37)) + 32'(j);
        return v[19:0];
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] rb;
        logic [9:0]  i;
        logic [9:0]  j;
        if (a >= DIR_A && a < DIR_A + 32'h1000) begin
            i = 10'((a - DIR_A) >> 2);
            return (i == 10'h3FF) ? 32'h0 : ((TBL_A + 32'(i) * 32'h1000) | 32'h1);
        end
        if (a >= DIR_B && a < DIR_B + 32'h1000) begin
            i = 10'((a - DIR_B) >> 2);
            return (i == 10'h3FF) ? 32'h0 : ((TBL_B + 32'(i) * 32'h1000) | 32'h1);
        end
        if (a >= TBL_A && a < TBL_A + 32'h0040_0000) rb = TBL_A;
        else if (a >= TBL_B && a < TBL_B + 32'h0040_0000) rb = TBL_B;
        else return 32'h0;
        i = 10'((a - rb) >> 12);
        j = 10'((a >> 2) & 32'h3FF);
        return (j == 10'h3FF) ? 32'h0 : {ppn_of(rb, i, j), 12'h001};
    endfunction

    function automatic logic [31:0] expect_pa(input logic [31:0] rb, input logic [31:0] lin);
        return {ppn_of(rb, lin[31:22], lin[21:12]), lin[11:0]};
    endfunction

    function automatic logic [31:0] page_lin(input int i, input int j, input int off);
        return (32'(i) << 22) | (32'(j) << 12) | 32'(off);
    endfunction

    // memory model: answers a held read after LAT cycles with a one-cycle strobe
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                cnt = 0;
            end else if (mem_req_valid) begin
                cnt++;
                if (cnt >= LAT) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(mem_req_addr);
                    mem_reads++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // fmode: 0 plain, 1 flush with the request, 2 flush during the walk
    task automatic xlate(input logic [31:0] lin, input logic [31:0] exp_pa, input bit exp_flt,
                         input int exp_reads, input int fmode, input string req);
        int r0;
        int lat;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_lin   = lin;
        tlb_flush = (fmode == 1);
        r0 = mem_reads;
        @(negedge clk);
        req_valid = 1'b0;
        tlb_flush = (fmode == 2);
        lat = 1;
        if (exp_reads > 0)
            chk(req_ready === 1'b0, "R9", "ready low during walk", 32'(req_ready), 32'd0);
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            tlb_flush = 1'b0;
            lat++;
        end
        tlb_flush = 1'b0;
        chk(rsp_valid === 1'b1, req, "response seen", 32'(rsp_valid), 32'd1);
        chk(rsp_fault === exp_flt, req, "fault flag", 32'(rsp_fault), 32'(exp_flt));
        if (!exp_flt)
            chk(rsp_phys === exp_pa, req, "physical address", rsp_phys, exp_pa);
        chk(mem_reads - r0 == exp_reads, req, "memory reads", 32'(mem_reads - r0),
            32'(exp_reads));
        if (exp_reads == 0)
            chk(lat == 1, req, "latency", 32'(lat), 32'd1);
        chk(req_ready === 1'b1, "R9", "ready at response", 32'(req_ready), 32'd1);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11", "response is one pulse", 32'(rsp_valid), 32'd0);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        tlb_flush = 1'b1;
        @(negedge clk);
        tlb_flush = 1'b0;
    endtask

    task automatic t_reset();
        chk(req_ready === 1'b1, "R9", "reset ready", 32'(req_ready), 32'd1);
        chk(rsp_valid === 1'b0, "R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(rsp_fault === 1'b0, "R11", "reset rsp_fault", 32'(rsp_fault), 32'd0);
        chk(mem_req_valid === 1'b0, "R10", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);
    endtask

    task automatic t_bypass();
        pg_en = 1'b0;
        xlate(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 0, 0, "R1");
        xlate(page_lin(1, 5, 12'h123), page_lin(1, 5, 12'h123), 1'b0, 0, 0, "R1");
    endtask

    task automatic t_walk_then_hit();
        logic [31:0] a;
        pg_en = 1'b1;
        a = page_lin(1, 5, 12'h123);
        xlate(a, expect_pa(TBL_A, a), 1'b0, 2, 0, "R3");
        a = page_lin(1, 5, 12'hFF0);
        xlate(a, expect_pa(TBL_A, a), 1'b0, 0, 0, "R4");
        a = page_lin(700, 1022, 12'h00C);
        xlate(a, expect_pa(TBL_A, a), 1'b0, 2, 0, "R2");
    endtask

    task automatic t_faults();
        logic [31:0] a;
        a = page_lin(1023, 1, 0);
        xlate(a, 32'h0, 1'b1, 1, 0, "R5");
        xlate(a, 32'h0, 1'b1, 1, 0, "R5");
        a = page_lin(2, 1023, 12'h040);
        xlate(a, 32'h0, 1'b1, 2, 0, "R5");
        xlate(a, 32'h0, 1'b1, 2, 0, "R5");
    endtask

    task automatic t_lru();
        pulse_flush();
        for (int k = 0; k < 32; k++)
            xlate(page_lin(3, k, k * 4), expect_pa(TBL_A, page_lin(3, k, k * 4)), 1'b0, 2, 0,
                  "R6");
        xlate(page_lin(3, 31, 8), expect_pa(TBL_A, page_lin(3, 31, 8)), 1'b0, 0, 0, "R6");
        xlate(page_lin(3, 0, 8), expect_pa(TBL_A, page_lin(3, 0, 8)), 1'b0, 0, 0, "R6");
        xlate(page_lin(3, 32, 0), expect_pa(TBL_A, page_lin(3, 32, 0)), 1'b0, 2, 0, "R6");
        xlate(page_lin(3, 0, 16), expect_pa(TBL_A, page_lin(3, 0, 16)), 1'b0, 0, 0, "R6");
        xlate(page_lin(3, 1, 0), expect_pa(TBL_A, page_lin(3, 1, 0)), 1'b0, 2, 0, "R6");
        xlate(page_lin(3, 3, 0), expect_pa(TBL_A, page_lin(3, 3, 0)), 1'b0, 0, 0, "R6");
        xlate(page_lin(3, 2, 0), expect_pa(TBL_A, page_lin(3, 2, 0)), 1'b0, 2, 0, "R6");
    endtask

    task automatic t_flush();
        logic [31:0] a;
        a = page_lin(3, 0, 12'h100);
        @(negedge clk);
        dir_base = DIR_B;
        pulse_flush();
        xlate(a, expect_pa(TBL_B, a), 1'b0, 2, 0, "R7");
        xlate(a, expect_pa(TBL_B, a), 1'b0, 0, 0, "R7");
        xlate(a, expect_pa(TBL_B, a), 1'b0, 2, 1, "R7");
        a = page_lin(5, 7, 12'h2A4);
        xlate(a, expect_pa(TBL_B, a), 1'b0, 2, 2, "R8");
        xlate(a, expect_pa(TBL_B, a), 1'b0, 2, 0, "R8");
        xlate(a, expect_pa(TBL_B, a), 1'b0, 0, 0, "R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_walk_then_hit();
        t_faults();
        t_lru();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule